// File: doc/BRIEF.md
# NAND Block-Erase Sequencer

This block runs the complete erase of one 8 KB block on a byte-wide NAND flash from the host side. A one-clock `start_i` pulse together with a 10-bit block number begins the operation. The sequencer drives the flash control strobes and a bidirectional 8-bit data bus. It sends the erase-setup command `0x60`, then a row address in two bytes, then the confirm command `0xD0`. It then waits for the device to finish. When it is done it pulses `done_o` and presents three result flags: pass, write-protected and timeout.

A build-time parameter chooses how completion is detected. In pin mode the sequencer waits until the synchronised ready/busy line goes high, issues the read-status command `0x70` and reads the status byte once. In polling mode it issues `0x70` and then keeps strobing the read enable until status bit 6 reads 1, without sending the command again. Polling mode still works when several devices share one wired ready/busy line. A guard counter limits the wait in both modes. The widths of the write-enable and read-enable strobes, and the delay after the confirm command, are parameters counted in clock cycles.

The controller is a single state machine with these states: IDLE, SETUP, ADDR_LO, ADDR_HI, CONFIRM, TWB, WAIT_RB, STAT_CMD, STAT_RD and FINISH. The transitions are:

- IDLE→SETUP on `start_i`.
- SETUP→ADDR_LO→ADDR_HI→CONFIRM→TWB, each after its write strobe completes.
- TWB→WAIT_RB in pin mode, or TWB→STAT_CMD in polling mode.
- WAIT_RB→STAT_CMD when ready is seen, or WAIT_RB→FINISH on timeout.
- STAT_CMD→STAT_RD.
- STAT_RD→FINISH in pin mode, or when ready is read, or on timeout.
- STAT_RD→STAT_RD for another poll.
- FINISH→IDLE.

Top module: `nand_erase_seq`

## Requirements
- R1: A `start_i` pulse in IDLE begins an erase. A `start_i` pulse while an erase is in progress has no effect: no second setup command is issued and the block number is not re-captured.
- R2: The first byte written is `0x60`. Every command byte is latched on the rising edge of `nand_we_n` with `nand_cle` = 1, `nand_ale` = 0 and `nand_ce_n` = 0.
- R3: Exactly two address bytes follow the setup command, both with `nand_ale` = 1 and `nand_cle` = 0. Byte 1 is `{block_i[3:0], 4'b0000}`: the four page-select bits are sent as zero. Byte 2 is `{2'b00, block_i[9:4]}`.
- R4: The confirm command `0xD0` is the byte written directly after the second address byte.
- R5: In pin mode the sequencer waits for `nand_rb_n` = 1, writes `0x70` and performs exactly one status read. `pass_o` is 1 when status bit 0 is 0.
- R6: In polling mode the sequencer writes `0x70` once and then repeats status reads until status bit 6 (ready) reads 1. It takes `pass_o` from bit 0 of that read.
- R7: `wp_o` is set when bit 7 of the first status read of an operation is 0.
- R8: If ready is not seen within `TIMEOUT_CYC` cycles after the confirm command, the operation ends with `tmo_o` = 1 and `pass_o` = 0.
- R9: `done_o` is high for exactly one clock per operation. `pass_o`, `wp_o` and `tmo_o` hold their values until the next accepted start. `busy_o` is high from the accepted start until the cycle after `done_o`.
- R10: The sequencer stops driving `nand_io` while `nand_re_n` is low, so the flash alone drives the bus during a read.
- R11: Each write strobe holds `nand_we_n` low for exactly `WE_LOW_CYC` clocks.
- R12: After reset `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, and `nand_cle`, `nand_ale`, `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an erase (accepted in IDLE only) |
| block_i | input | 10 | Block number to erase |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| pass_o | output | 1 | Erase succeeded |
| wp_o | output | 1 | Device reported write protection |
| tmo_o | output | 1 | Ready never appeared within the limit |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_rb_n | input | 1 | Ready/busy, low while busy |
| nand_io | inout | 8 | Command, address and status bus |

## Verification
The hardest case to reach is a polling-mode erase whose ready bit comes up only after many reads. In that case the sequencer must keep strobing the read enable without resending `0x70`, and it must still stop on the guard limit when ready never appears. The bench pairs each sequencer instance with a behavioural flash that has a programmable busy length and a "never ready" switch. This lets it force both long polls and timeouts. A second start pulse is injected in the middle of an erase, and the flash's command log shows that it was ignored.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_CONFIRM,
        ST_TWB,
        ST_WAIT_RB,
        ST_STAT_CMD,
        ST_STAT_RD,
        ST_FINISH
    } seq_state_e;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;

    localparam int STAT_FAIL_BIT = 0;
    localparam int STAT_RDY_BIT  = 6;
    localparam int STAT_WPN_BIT  = 7;

endpackage

// File: rtl/nes_cycle_timer.sv
module nes_cycle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/nes_timeout_guard.sv
module nes_timeout_guard #(
    parameter int LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIM);

    p_guard_saturates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clear_i) |=> expired_o);
endmodule

// File: rtl/nes_rb_sync.sv
module nes_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_i,
    output logic ready_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], rb_n_i};
        end
    end

    assign ready_o = sh_q[STAGES-1];
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int BLOCK_W     = 10,
    parameter int PAGE_BITS   = 4,
    parameter bit WAIT_ON_PIN = 1'b1,
    parameter int WE_LOW_CYC  = 2,
    parameter int WE_HIGH_CYC = 2,
    parameter int RE_LOW_CYC  = 3,
    parameter int RE_HIGH_CYC = 2,
    parameter int TWB_CYC     = 4,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] block_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               pass_o,
    output logic               wp_o,
    output logic               tmo_o,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_ce_n,
    output logic               nand_we_n,
    output logic               nand_re_n,
    input  logic               nand_rb_n,
    inout  wire  [7:0]         nand_io
);
    localparam int ROW_W = BLOCK_W + PAGE_BITS;
    localparam int TW    = $clog2(WE_LOW_CYC + WE_HIGH_CYC + RE_LOW_CYC + RE_HIGH_CYC + TWB_CYC + 1);
    localparam logic [TW-1:0] WE_LO_L = TW'(WE_LOW_CYC - 1);
    localparam logic [TW-1:0] WE_HI_L = TW'(WE_HIGH_CYC - 1);
    localparam logic [TW-1:0] RE_LO_L = TW'(RE_LOW_CYC - 1);
    localparam logic [TW-1:0] RE_HI_L = TW'(RE_HIGH_CYC - 1);
    localparam logic [TW-1:0] TWB_L   = TW'(TWB_CYC - 1);

    seq_state_e      state_q, state_d;
    logic            ph_q, ph_d;          // 0: strobe asserted, 1: strobe released
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_exp;
    logic            tmo_exp;
    logic            rb_ready;
    logic [15:0]     row_q;
    logic            st_fail_q, st_rdy_q, first_rd_q;
    logic            fin_tmo;
    logic            accept;
    logic [7:0]      io_out;
    logic            io_oe;

    function automatic logic [TW-1:0] entry_load(seq_state_e s);
        case (s)
            ST_TWB:     return TWB_L;
            ST_STAT_RD: return RE_LO_L;
            default:    return WE_LO_L;
        endcase
    endfunction

    nes_cycle_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .expired_o(t_exp)
    );

    nes_timeout_guard #(.LIMIT(TIMEOUT_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .clear_i(accept),
        .run_i(state_q == ST_TWB || state_q == ST_WAIT_RB ||
               state_q == ST_STAT_CMD || state_q == ST_STAT_RD),
        .expired_o(tmo_exp)
    );

    nes_rb_sync #(.STAGES(2)) u_rb_sync (
        .clk(clk), .rst_n(rst_n), .rb_n_i(nand_rb_n), .ready_o(rb_ready)
    );

    assign accept = (state_q == ST_IDLE) && start_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        t_load  = 1'b0;
        t_val   = WE_LO_L;
        fin_tmo = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SETUP;
                    ph_d    = 1'b0;
                    t_load  = 1'b1;
                    t_val   = WE_LO_L;
                end
            end
            ST_SETUP, ST_ADDR_LO, ST_ADDR_HI, ST_CONFIRM, ST_STAT_CMD: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (!ph_q) begin
                        ph_d  = 1'b1;
                        t_val = WE_HI_L;
                    end else begin
                        ph_d = 1'b0;
                        unique case (state_q)
                            ST_SETUP:   state_d = ST_ADDR_LO;
                            ST_ADDR_LO: state_d = ST_ADDR_HI;
                            ST_ADDR_HI: state_d = ST_CONFIRM;
                            ST_CONFIRM: state_d = ST_TWB;
                            default:    state_d = ST_STAT_RD;
                        endcase
                        t_val = entry_load(state_d);
                    end
                end
            end
            ST_TWB: begin
                if (t_exp) begin
                    state_d = WAIT_ON_PIN ? ST_WAIT_RB : ST_STAT_CMD;
                    ph_d    = 1'b0;
                    t_load  = 1'b1;
                    t_val   = WE_LO_L;
                end
            end
            ST_WAIT_RB: begin
                if (rb_ready) begin
                    state_d = ST_STAT_CMD;
                    ph_d    = 1'b0;
                    t_load  = 1'b1;
                    t_val   = WE_LO_L;
                end else if (tmo_exp) begin
                    state_d = ST_FINISH;
                    fin_tmo = 1'b1;
                end
            end
            ST_STAT_RD: begin
                if (t_exp) begin
                    if (!ph_q) begin
                        ph_d   = 1'b1;
                        t_load = 1'b1;
                        t_val  = RE_HI_L;
                    end else if (WAIT_ON_PIN || st_rdy_q) begin
                        state_d = ST_FINISH;
                    end else if (tmo_exp) begin
                        state_d = ST_FINISH;
                        fin_tmo = 1'b1;
                    end else begin
                        ph_d   = 1'b0;
                        t_load = 1'b1;
                        t_val  = RE_LO_L;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Captured block row and status results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q      <= '0;
            st_fail_q  <= 1'b0;
            st_rdy_q   <= 1'b0;
            first_rd_q <= 1'b0;
            pass_o     <= 1'b0;
            wp_o       <= 1'b0;
            tmo_o      <= 1'b0;
        end else begin
            if (accept) begin
                row_q      <= 16'({block_i, {PAGE_BITS{1'b0}}});
                first_rd_q <= 1'b1;
                st_rdy_q   <= 1'b0;
                pass_o     <= 1'b0;
                wp_o       <= 1'b0;
                tmo_o      <= 1'b0;
            end
            if (state_q == ST_STAT_RD && !ph_q && t_exp) begin
                st_fail_q  <= nand_io[STAT_FAIL_BIT];
                st_rdy_q   <= nand_io[STAT_RDY_BIT];
                first_rd_q <= 1'b0;
                if (first_rd_q && !nand_io[STAT_WPN_BIT]) begin
                    wp_o <= 1'b1;
                end
            end
            if (state_d == ST_FINISH && state_q != ST_FINISH) begin
                tmo_o  <= fin_tmo;
                pass_o <= !fin_tmo && !st_fail_q;
            end
        end
    end

    // Output decode
    always_comb begin
        nand_cle  = 1'b0;
        nand_ale  = 1'b0;
        nand_ce_n = 1'b0;
        nand_we_n = 1'b1;
        nand_re_n = 1'b1;
        io_out    = OP_ERASE_GO;
        io_oe     = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                nand_ce_n = 1'b1;
                io_oe     = 1'b0;
            end
            ST_SETUP: begin
                nand_cle  = 1'b1;
                nand_we_n = ph_q;
                io_out    = OP_ERASE_SETUP;
            end
            ST_ADDR_LO: begin
                nand_ale  = 1'b1;
                nand_we_n = ph_q;
                io_out    = row_q[7:0];
            end
            ST_ADDR_HI: begin
                nand_ale  = 1'b1;
                nand_we_n = ph_q;
                io_out    = {2'b00, row_q[ROW_W-1-(ROW_W-14) -: 6]};
            end
            ST_CONFIRM: begin
                nand_cle  = 1'b1;
                nand_we_n = ph_q;
                io_out    = OP_ERASE_GO;
            end
            ST_STAT_CMD: begin
                nand_cle  = 1'b1;
                nand_we_n = ph_q;
                io_out    = OP_STATUS;
            end
            ST_STAT_RD: begin
                nand_re_n = ph_q;
                io_out    = OP_STATUS;
                io_oe     = ph_q;
            end
            default: begin
            end
        endcase
    end

    assign nand_io = io_oe ? io_out : 8'hzz;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = (state_q == ST_FINISH);

    // Assertions
    p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_cmd_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle && !nand_we_n) |->
        (nand_io == OP_ERASE_SETUP || nand_io == OP_ERASE_GO || nand_io == OP_STATUS));

    p_addr_hi_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_HI) |-> (nand_ale && nand_io[7:6] == 2'b00));

    p_bus_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !io_oe);

    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> (state_q != ST_SETUP || $stable(state_q)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_tmo_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && tmo_o) |-> !pass_o);

    p_one_read_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_ON_PIN && state_q == ST_STAT_RD && ph_q && t_exp) |=> done_o);
endmodule

// File: tb/nand_erase_seq_tb_top.sv
`timescale 1ns/1ps

module nand_flash_model (
    input  logic       clk,
    input  logic       cle,
    input  logic       ale,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       re_n,
    inout  wire  [7:0] io,
    output logic       rb_n,
    input  int         busy_len,
    input  logic       fail_i,
    input  logic       wp_n_i,
    input  logic       hang_i,
    input  logic       clr_i
);
    logic [7:0] log_val [16];
    logic       log_cmd [16];
    int         n_log, n_reads, we_min, we_max, we_run, busy_cnt, conflicts;
    logic       we_prev, re_prev, ready;
    logic [7:0] status;

    assign status = {wp_n_i, ready, 5'b00000, ready & fail_i};
    assign io = (!re_n && !ce_n) ? status : 8'hzz;

    always @(posedge clk) begin
        if (clr_i) begin
            n_log <= 0; n_reads <= 0; we_min <= 1000; we_max <= 0; we_run <= 0;
            busy_cnt <= 0; conflicts <= 0; we_prev <= 1'b1; re_prev <= 1'b1;
            ready <= 1'b1; rb_n <= 1'b1;
        end else begin
            we_prev <= we_n;
            re_prev <= re_n;
            if (!we_n) we_run <= we_run + 1;
            if (!we_prev && we_n && !ce_n) begin
                if (we_run < we_min) we_min <= we_run;
                if (we_run > we_max) we_max <= we_run;
                we_run <= 0;
                if (n_log < 16) begin
                    log_val[n_log] <= io;
                    log_cmd[n_log] <= cle;
                    n_log <= n_log + 1;
                end
                if (cle && io == 8'hD0) begin
                    ready <= 1'b0; rb_n <= 1'b0; busy_cnt <= busy_len;
                end
            end else if (!ready && !hang_i) begin
                if (busy_cnt == 0) begin
                    ready <= 1'b1; rb_n <= 1'b1;
                end else begin
                    busy_cnt <= busy_cnt - 1;
                end
            end
            if (re_prev && !re_n) n_reads <= n_reads + 1;
            if (!re_n && !ce_n && io !== status) conflicts <= conflicts + 1;
        end
    end
endmodule

module nand_erase_seq_tb_top;
    localparam int TMO = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // pin-mode instance
    logic       a_start = 1'b0;
    logic [9:0] a_blk = '0;
    logic       a_busy, a_done, a_pass, a_wp, a_tmo, a_cle, a_ale, a_ce_n, a_we_n, a_re_n, a_rb_n;
    wire  [7:0] a_io;
    int         a_blen = 10;
    logic       a_fail = 1'b0, a_wpn = 1'b1, a_hang = 1'b0, a_clr = 1'b1;

    // polling-mode instance
    logic       b_start = 1'b0;
    logic [9:0] b_blk = '0;
    logic       b_busy, b_done, b_pass, b_wp, b_tmo, b_cle, b_ale, b_ce_n, b_we_n, b_re_n, b_rb_n;
    wire  [7:0] b_io;
    int         b_blen = 10;
    logic       b_fail = 1'b0, b_wpn = 1'b1, b_hang = 1'b0, b_clr = 1'b1;

    nand_erase_seq #(.WAIT_ON_PIN(1'b1), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(a_start), .block_i(a_blk),
        .busy_o(a_busy), .done_o(a_done), .pass_o(a_pass), .wp_o(a_wp), .tmo_o(a_tmo),
        .nand_cle(a_cle), .nand_ale(a_ale), .nand_ce_n(a_ce_n), .nand_we_n(a_we_n),
        .nand_re_n(a_re_n), .nand_rb_n(a_rb_n), .nand_io(a_io)
    );
    nand_flash_model fm_pin (
        .clk(clk), .cle(a_cle), .ale(a_ale), .ce_n(a_ce_n), .we_n(a_we_n), .re_n(a_re_n),
        .io(a_io), .rb_n(a_rb_n), .busy_len(a_blen), .fail_i(a_fail), .wp_n_i(a_wpn),
        .hang_i(a_hang), .clr_i(a_clr)
    );

    nand_erase_seq #(.WAIT_ON_PIN(1'b0), .TIMEOUT_CYC(TMO)) dut_poll_i (
        .clk(clk), .rst_n(rst_n), .start_i(b_start), .block_i(b_blk),
        .busy_o(b_busy), .done_o(b_done), .pass_o(b_pass), .wp_o(b_wp), .tmo_o(b_tmo),
        .nand_cle(b_cle), .nand_ale(b_ale), .nand_ce_n(b_ce_n), .nand_we_n(b_we_n),
        .nand_re_n(b_re_n), .nand_rb_n(b_rb_n), .nand_io(b_io)
    );
    nand_flash_model fm_poll (
        .clk(clk), .cle(b_cle), .ale(b_ale), .ce_n(b_ce_n), .we_n(b_we_n), .re_n(b_re_n),
        .io(b_io), .rb_n(b_rb_n), .busy_len(b_blen), .fail_i(b_fail), .wp_n_i(b_wpn),
        .hang_i(b_hang), .clr_i(b_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            finish_run();
        end
    end

    // Pin-mode run: configure flash, start, optionally inject a second start, wait for done.
    task automatic run_pin(input logic [9:0] blk, input int blen, input logic fl,
                           input logic wpn, input logic hg, input bit inject);
        @(negedge clk);
        a_blen = blen; a_fail = fl; a_wpn = wpn; a_hang = hg; a_clr = 1'b1;
        @(negedge clk);
        a_clr = 1'b0; a_blk = blk; a_start = 1'b1;
        @(negedge clk);
        a_start = 1'b0;
        if (inject) begin
            repeat (8) @(negedge clk);
            a_blk = ~blk; a_start = 1'b1;
            @(negedge clk);
            a_start = 1'b0;
        end
        for (int i = 0; i < 6000; i++) begin
            if (a_done) break;
            @(negedge clk);
        end
        chk("R9 pin done seen", int'(a_done), 1);
    endtask

    task automatic run_poll(input logic [9:0] blk, input int blen, input logic fl,
                            input logic wpn, input logic hg);
        @(negedge clk);
        b_blen = blen; b_fail = fl; b_wpn = wpn; b_hang = hg; b_clr = 1'b1;
        @(negedge clk);
        b_clr = 1'b0; b_blk = blk; b_start = 1'b1;
        @(negedge clk);
        b_start = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            if (b_done) break;
            @(negedge clk);
        end
        chk("R9 poll done seen", int'(b_done), 1);
    endtask

    task automatic t_reset();
        chk("R12 ce_n", int'(a_ce_n), 1);
        chk("R12 we_n", int'(a_we_n), 1);
        chk("R12 re_n", int'(a_re_n), 1);
        chk("R12 cle|ale", int'(a_cle | a_ale), 0);
        chk("R12 busy|done", int'(a_busy | a_done), 0);
    endtask

    task automatic t_pin_pass();
        run_pin(10'h2A5, 20, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R5 pass", int'(a_pass), 1);
        chk("R7 wp clear", int'(a_wp), 0);
        chk("R8 tmo clear", int'(a_tmo), 0);
        chk("R1 log length (second start ignored)", fm_pin.n_log, 5);
        chk("R2 first byte 0x60", int'(fm_pin.log_val[0]), 8'h60);
        chk("R2 first byte is command", int'(fm_pin.log_cmd[0]), 1);
        chk("R3 addr1", int'(fm_pin.log_val[1]), 8'h50);
        chk("R3 addr1 is address", int'(fm_pin.log_cmd[1]), 0);
        chk("R3 addr2", int'(fm_pin.log_val[2]), 8'h2A);
        chk("R4 confirm 0xD0", int'(fm_pin.log_val[3]), 8'hD0);
        chk("R4 confirm is command", int'(fm_pin.log_cmd[3]), 1);
        chk("R5 status cmd 0x70", int'(fm_pin.log_val[4]), 8'h70);
        chk("R5 single status read", fm_pin.n_reads, 1);
        chk("R11 we low min", fm_pin.we_min, 2);
        chk("R11 we low max", fm_pin.we_max, 2);
        chk("R10 bus conflicts", fm_pin.conflicts, 0);
        @(negedge clk);
        chk("R9 done one clock", int'(a_done), 0);
        chk("R9 busy low after done", int'(a_busy), 0);
        repeat (5) @(negedge clk);
        chk("R9 pass held", int'(a_pass), 1);
    endtask

    task automatic t_pin_fail_wp();
        run_pin(10'h001, 5, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 fail reported", int'(a_pass), 0);
        chk("R7 wp flagged", int'(a_wp), 1);
        chk("R8 no tmo", int'(a_tmo), 0);
        chk("R3 addr1 block1", int'(fm_pin.log_val[1]), 8'h10);
        @(negedge clk);
        chk("R9 wp held", int'(a_wp), 1);
    endtask

    task automatic t_pin_timeout();
        run_pin(10'h100, 5, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 pin tmo", int'(a_tmo), 1);
        chk("R8 pin pass low", int'(a_pass), 0);
        chk("R5 no read while busy", fm_pin.n_reads, 0);
        chk("R4 four bytes only", fm_pin.n_log, 4);
    endtask

    task automatic t_poll_long();
        run_poll(10'h3FF, 60, 1'b0, 1'b1, 1'b0);
        chk("R6 pass", int'(b_pass), 1);
        chk("R6 many reads", int'(fm_poll.n_reads > 2), 1);
        chk("R6 single 0x70", fm_poll.n_log, 5);
        chk("R6 last byte 0x70", int'(fm_poll.log_val[4]), 8'h70);
        chk("R3 addr1 max block", int'(fm_poll.log_val[1]), 8'hF0);
        chk("R3 addr2 max block", int'(fm_poll.log_val[2]), 8'h3F);
        chk("R10 poll bus conflicts", fm_poll.conflicts, 0);
        chk("R8 no tmo", int'(b_tmo), 0);
    endtask

    task automatic t_poll_fail_zero();
        run_poll(10'h000, 3, 1'b1, 1'b1, 1'b0);
        chk("R6 fail", int'(b_pass), 0);
        chk("R7 no wp", int'(b_wp), 0);
        chk("R3 addr1 zero", int'(fm_poll.log_val[1]), 8'h00);
        chk("R3 addr2 zero", int'(fm_poll.log_val[2]), 8'h00);
    endtask

    task automatic t_poll_timeout();
        run_poll(10'h0AA, 5, 1'b0, 1'b1, 1'b1);
        chk("R8 poll tmo", int'(b_tmo), 1);
        chk("R8 poll pass low", int'(b_pass), 0);
        chk("R6 still one 0x70", fm_poll.n_log, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        a_clr = 1'b0; b_clr = 1'b0;
        @(negedge clk);
        t_reset();
        t_pin_pass();
        t_pin_fail_wp();
        t_pin_timeout();
        t_poll_long();
        t_poll_fail_zero();
        t_poll_timeout();
        finish_run();
    end
endmodule